// File: doc/BRIEF.md
# Frame Header Pixel Format Decoder

This block sits beside the frame fetch engine of a display controller. At the start of each frame the fetch engine hands it the first 16-bit word of the frame buffer and pulses `start`. A 3-bit depth code inside that word sets the pixel depth and the size of the palette region that sits ahead of the pixel data. From that depth and the panel geometry, the decoder works out several results:

- where pixel data begins in the buffer;
- how many bytes one line takes;
- whether 16-bit pixels use the 12-bit or the 16-bit colour layout;
- which lines are visible once the subpanel setting is applied.

It also checks that the whole frame fits in the buffer it was given. If it does not, it pulses a sync error, and the owner of the enable bit then clears that bit. All results are registered and appear together with a one-cycle `done` pulse. The decoder does not fetch memory.

Top module: `fhdr_decoder`

## Requirements
- R1: While `rst_n` is low at a clock edge, every output is cleared to zero on that edge.
- R2: A `start` seen at a rising edge while `ctrl_enable` is 1 and `load_mode` is not 1 is accepted. All outputs update on that edge and `done` is high for exactly that one cycle. Any other `start` is ignored: `done` stays low and every result output keeps its value.
- R3: The depth code is `hdr_word[14:12]`. Code 1 gives `bpp`=2, code 2 gives 4, code 3 gives 8, and codes 4 to 7 give 16. For these codes `frame_ok` is 1 unless R7 applies.
- R4: Depth code 0 is unsupported. The decoder still gives `done`, but with `frame_ok`=0, `bpp`=0, `line_step`=0 and `sync_err`=0, whatever the buffer size.
- R5: `color16` is 1 only when `bpp` is 16 and `active_panel` is 1. A 16-bit passive panel gives `color16`=0, which selects the 12-bit colour layout.
- R6: When `load_mode` is 2, `pix_offset` is 0. For any other mode it is 512 when the depth code is 3 to 7, and 32 otherwise (this includes code 0).
- R7: For a supported code, if `pix_offset + floor(width*height*bpp/8)` is greater than `buf_size + 2`, then `sync_err` is 1 and `frame_ok` is 0 for the `done` cycle only. A sum exactly equal to `buf_size + 2` is accepted.
- R8: `line_step` is `floor(width*bpp/8)` bytes, where `width` is the pixel count per line.
- R9: When `subpanel[31]` is 0, `first_line` is 0 and `line_count` equals `height`. The other subpanel bits then have no effect.
- R10: When `subpanel[31]` and `subpanel[29]` are both 1, `first_line` is `subpanel[25:16]` and `line_count` equals `height`.
- R11: When `subpanel[31]` is 1 and `subpanel[29]` is 0, `first_line` is 0 and `line_count` is `subpanel[25:16]`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| start | input | 1 | Decode request for a new frame |
| ctrl_enable | input | 1 | Controller enable; a start is ignored while it is 0 |
| load_mode | input | 2 | Palette-load mode: 1 means no decode, 2 means no header region |
| active_panel | input | 1 | 1 for an active-matrix panel |
| hdr_word | input | 16 | First 16-bit word of the frame buffer |
| width | input | DIM_W (11) | Pixels per line |
| height | input | DIM_W (11) | Lines per frame |
| buf_size | input | BUF_W (24) | Frame buffer size in bytes |
| subpanel | input | 32 | Subpanel setting |
| done | output | 1 | One-cycle pulse when the results are valid |
| frame_ok | output | 1 | Frame is supported and fits in the buffer |
| sync_err | output | 1 | One-cycle pulse when the frame overruns the buffer |
| bpp | output | 5 | Bits per pixel: 0, 2, 4, 8 or 16 |
| color16 | output | 1 | 1 for the 16-bit colour layout, 0 for the 12-bit layout |
| pix_offset | output | 10 | Byte offset of the first pixel |
| line_step | output | DIM_W+2 (13) | Bytes per line |
| first_line | output | 10 | First displayed line |
| line_count | output | DIM_W (11) | Number of displayed lines |

## Verification
The bench tests the size check exactly at `buf_size + 2` and one byte past it. A design that used `>=`, or that dropped the slack of two bytes, would then flag a valid frame or pass an overrun.

It uses code 7 and a header word with bit 15 set, so that a field read from the wrong bits or a decode of codes 5 to 7 as unsupported shows up. Code 0 is paired with a zero-size buffer, which catches a design that still applies the size check to an unsupported frame.

Line-step truncation is driven with a 3-pixel line at 2 bits per pixel. The subpanel select bit is also set while the subpanel enable is clear, and that setting must have no effect. Starts with the controller disabled, or in mode 1, must leave every output unchanged.

// File: rtl/fhdr_pkg.sv
// Package: shared constants for the frame header decoder.
// Assumes the depth field and the subpanel field positions are fixed,
// because neighbouring blocks decode the same words.
package fhdr_pkg;
    localparam int DEPTH_LSB   = 12;   // depth code lowest bit in header word
    localparam int DEPTH_W     = 3;
    localparam int OFS_W       = 10;
    localparam int OFS_LONG    = 512;  // full palette ahead of pixels
    localparam int OFS_SHORT   = 32;   // short palette ahead of pixels
    localparam int SUB_EN_BIT  = 31;
    localparam int SUB_SEL_BIT = 29;
    localparam int SUB_FLD_LSB = 16;
    localparam int SUB_FLD_W   = 10;
    localparam logic [1:0] MODE_NO_DECODE = 2'd1;
    localparam logic [1:0] MODE_NO_HEADER = 2'd2;

    // Result of decoding the depth code
    typedef struct packed {
        logic [4:0]       bpp;
        logic             supported;
        logic             color16;
        logic [OFS_W-1:0] offset;
    } depth_info_t;
endpackage

// File: rtl/fhdr_depth.sv
// Module: fhdr_depth
// Turns the depth code of the header word into bits per pixel, colour
// layout and the byte offset of pixel data. Purely combinational.
// Assumes the caller registers the results.
module fhdr_depth
    import fhdr_pkg::*;
(
    input  logic [15:0]  hdr_word,
    input  logic         active_panel,
    input  logic [1:0]   load_mode,
    output depth_info_t  info
);
    logic [DEPTH_W-1:0] code;
    logic               unused_hdr;

    assign code       = hdr_word[DEPTH_LSB +: DEPTH_W];
    assign unused_hdr = ^{hdr_word[15], hdr_word[DEPTH_LSB-1:0]};

    // Decode depth, colour layout and palette skip from the code
    always_comb begin
        info = '0;
        case (code)
            3'd0:    info.bpp = 5'd0;
            3'd1:    info.bpp = 5'd2;
            3'd2:    info.bpp = 5'd4;
            3'd3:    info.bpp = 5'd8;
            default: info.bpp = 5'd16;
        endcase
        info.supported = (code != 3'd0);
        info.color16   = (code >= 3'd4) && active_panel;
        if (load_mode == MODE_NO_HEADER)
            info.offset = '0;
        else if (code >= 3'd3)
            info.offset = OFS_W'(OFS_LONG);
        else
            info.offset = OFS_W'(OFS_SHORT);
    end
endmodule

// File: rtl/fhdr_geom.sv
// Module: fhdr_geom
// Computes the line step and checks that the frame fits its buffer.
// Combinational. Assumes width and height are pixel and line counts.
module fhdr_geom
    import fhdr_pkg::*;
#(
    parameter int DIM_W = 11,
    parameter int BUF_W = 24
) (
    input  logic [DIM_W-1:0] width,
    input  logic [DIM_W-1:0] height,
    input  logic [4:0]       bpp,
    input  logic [OFS_W-1:0] offset,
    input  logic             supported,
    input  logic [BUF_W-1:0] buf_size,
    output logic [DIM_W+1:0] line_step,
    output logic             overrun
);
    localparam int STEP_W = DIM_W + 5;
    localparam int PROD_W = 2 * DIM_W + 5;
    localparam int CMP_W  = ((PROD_W > BUF_W) ? PROD_W : BUF_W) + 2;

    logic [STEP_W-1:0] line_bits;
    logic [PROD_W-1:0] frame_bits;
    logic [CMP_W-1:0]  need, limit;

    // Bytes per line, truncated
    always_comb begin
        line_bits = STEP_W'(width) * STEP_W'(bpp);
        line_step = supported ? line_bits[STEP_W-1:3] : '0;
    end

    // Header plus pixel bytes against buffer size with two bytes of slack
    always_comb begin
        frame_bits = PROD_W'(width) * PROD_W'(height) * PROD_W'(bpp);
        need       = CMP_W'(frame_bits >> 3) + CMP_W'(offset);
        limit      = CMP_W'(buf_size) + CMP_W'(2);
        overrun    = supported && (need > limit);
    end
endmodule

// File: rtl/fhdr_window.sv
// Module: fhdr_window
// Applies the subpanel setting to choose the first line and line count.
// Combinational. Assumes DIM_W is at least the subpanel field width.
module fhdr_window
    import fhdr_pkg::*;
#(
    parameter int DIM_W = 11
) (
    input  logic [31:0]          subpanel,
    input  logic [DIM_W-1:0]     height,
    output logic [SUB_FLD_W-1:0] first_line,
    output logic [DIM_W-1:0]     line_count
);
    logic [SUB_FLD_W-1:0] fld;
    logic                 unused_sub;

    assign fld        = subpanel[SUB_FLD_LSB +: SUB_FLD_W];
    assign unused_sub = ^{subpanel[30], subpanel[28:26], subpanel[15:0]};

    // Select start line or shortened height
    always_comb begin
        first_line = '0;
        line_count = height;
        if (subpanel[SUB_EN_BIT]) begin
            if (subpanel[SUB_SEL_BIT])
                first_line = fld;
            else
                line_count = DIM_W'(fld);
        end
    end
endmodule

// File: rtl/fhdr_decoder.sv
// Module: fhdr_decoder (top)
// Registers the decoded frame format one cycle after an accepted start,
// with a done pulse. Assumes the enable owner clears its enable on sync_err.
module fhdr_decoder
    import fhdr_pkg::*;
#(
    parameter int DIM_W = 11,
    parameter int BUF_W = 24
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 start,
    input  logic                 ctrl_enable,
    input  logic [1:0]           load_mode,
    input  logic                 active_panel,
    input  logic [15:0]          hdr_word,
    input  logic [DIM_W-1:0]     width,
    input  logic [DIM_W-1:0]     height,
    input  logic [BUF_W-1:0]     buf_size,
    input  logic [31:0]          subpanel,
    output logic                 done,
    output logic                 frame_ok,
    output logic                 sync_err,
    output logic [4:0]           bpp,
    output logic                 color16,
    output logic [OFS_W-1:0]     pix_offset,
    output logic [DIM_W+1:0]     line_step,
    output logic [SUB_FLD_W-1:0] first_line,
    output logic [DIM_W-1:0]     line_count
);
    depth_info_t          dinfo;
    logic [DIM_W+1:0]     step_c;
    logic                 overrun_c;
    logic [SUB_FLD_W-1:0] first_c;
    logic [DIM_W-1:0]     count_c;
    logic                 accept;

    fhdr_depth u_depth (
        .hdr_word     (hdr_word),
        .active_panel (active_panel),
        .load_mode    (load_mode),
        .info         (dinfo)
    );

    fhdr_geom #(.DIM_W(DIM_W), .BUF_W(BUF_W)) u_geom (
        .width     (width),
        .height    (height),
        .bpp       (dinfo.bpp),
        .offset    (dinfo.offset),
        .supported (dinfo.supported),
        .buf_size  (buf_size),
        .line_step (step_c),
        .overrun   (overrun_c)
    );

    fhdr_window #(.DIM_W(DIM_W)) u_window (
        .subpanel   (subpanel),
        .height     (height),
        .first_line (first_c),
        .line_count (count_c)
    );

    assign accept = start && ctrl_enable && (load_mode != MODE_NO_DECODE);

    // Pulse outputs: done and sync error last one cycle
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            done     <= 1'b0;
            sync_err <= 1'b0;
        end else begin
            done     <= accept;
            sync_err <= accept && overrun_c;
        end
    end

    // Result registers, loaded only on an accepted start
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            frame_ok   <= 1'b0;
            bpp        <= '0;
            color16    <= 1'b0;
            pix_offset <= '0;
            line_step  <= '0;
            first_line <= '0;
            line_count <= '0;
        end else if (accept) begin
            frame_ok   <= dinfo.supported && !overrun_c;
            bpp        <= dinfo.bpp;
            color16    <= dinfo.color16;
            pix_offset <= dinfo.offset;
            line_step  <= step_c;
            first_line <= first_c;
            line_count <= count_c;
        end
    end

    p_done_follows_start_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (done == $past(start && ctrl_enable && load_mode != 2'd1)));

    p_hold_when_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !done) |-> ($stable(bpp) && $stable(line_step) && $stable(pix_offset)));

    p_bpp_legal_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (done && frame_ok) |-> ($onehot0(bpp) && bpp >= 5'd2));

    p_unsupported_quiet_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (done && bpp == 5'd0) |-> (!sync_err && !frame_ok && line_step == '0));

    p_color_needs_16_r5: assert property (@(posedge clk) disable iff (!rst_n)
        color16 |-> (bpp == 5'd16));

    p_mode2_no_offset_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (done && $past(load_mode) == 2'd2) |-> (pix_offset == '0));

    p_err_blocks_frame_r7: assert property (@(posedge clk) disable iff (!rst_n)
        sync_err |-> (done && !frame_ok));
endmodule

// File: tb/fhdr_decoder_test.sv
`timescale 1ns/1ps
module fhdr_decoder_test;
    localparam int DIM_W = 11;
    localparam int BUF_W = 24;

    typedef struct packed {
        logic [15:0]      hdr;
        logic             act;
        logic [1:0]       mode;
        logic [DIM_W-1:0] w;
        logic [DIM_W-1:0] h;
        logic [BUF_W-1:0] bsz;
        logic [31:0]      sub;
        logic [4:0]       e_bpp;
        logic [9:0]       e_off;
        logic             e_c16;
        logic [DIM_W+1:0] e_step;
        logic [9:0]       e_first;
        logic [DIM_W-1:0] e_cnt;
        logic             e_ok;
        logic             e_err;
    } vec_t;

    localparam int NVEC = 10;
    localparam vec_t VECS [NVEC] = '{
        '{16'h1000, 1'b0, 2'd0, 11'd320, 11'd240, 24'd65536, 32'h0000_0000,
          5'd2,  10'd32,  1'b0, 13'd80, 10'd0,  11'd240, 1'b1, 1'b0},
        '{16'h2abc, 1'b1, 2'd0, 11'd100, 11'd50,  24'd4096,  32'h0000_0000,
          5'd4,  10'd32,  1'b0, 13'd50, 10'd0,  11'd50,  1'b1, 1'b0},
        '{16'h3000, 1'b0, 2'd0, 11'd64,  11'd16,  24'd2048,  32'hA00A_0000,
          5'd8,  10'd512, 1'b0, 13'd64, 10'd10, 11'd16,  1'b1, 1'b0},
        '{16'h4000, 1'b0, 2'd0, 11'd10,  11'd10,  24'd712,   32'h8005_0000,
          5'd16, 10'd512, 1'b0, 13'd20, 10'd0,  11'd5,   1'b1, 1'b0},
        '{16'h7fff, 1'b1, 2'd0, 11'd10,  11'd10,  24'd709,   32'h0000_0000,
          5'd16, 10'd512, 1'b1, 13'd20, 10'd0,  11'd10,  1'b0, 1'b1},
        '{16'h4000, 1'b1, 2'd0, 11'd10,  11'd10,  24'd710,   32'h0000_0000,
          5'd16, 10'd512, 1'b1, 13'd20, 10'd0,  11'd10,  1'b1, 1'b0},
        '{16'h3000, 1'b0, 2'd2, 11'd8,   11'd4,   24'd30,    32'h0000_0000,
          5'd8,  10'd0,   1'b0, 13'd8,  10'd0,  11'd4,   1'b1, 1'b0},
        '{16'h8fff, 1'b1, 2'd0, 11'd10,  11'd10,  24'd0,     32'h0000_0000,
          5'd0,  10'd32,  1'b0, 13'd0,  10'd0,  11'd10,  1'b0, 1'b0},
        '{16'h1000, 1'b0, 2'd0, 11'd3,   11'd1,   24'd100,   32'h2003_0000,
          5'd2,  10'd32,  1'b0, 13'd0,  10'd0,  11'd1,   1'b1, 1'b0},
        '{16'h2000, 1'b0, 2'd3, 11'd4,   11'd2,   24'd100,   32'h0000_0000,
          5'd4,  10'd32,  1'b0, 13'd2,  10'd0,  11'd2,   1'b1, 1'b0}
    };

    logic                 clk = 1'b0;
    logic                 rst_n;
    logic                 start;
    logic                 ctrl_enable;
    logic [1:0]           load_mode;
    logic                 active_panel;
    logic [15:0]          hdr_word;
    logic [DIM_W-1:0]     width;
    logic [DIM_W-1:0]     height;
    logic [BUF_W-1:0]     buf_size;
    logic [31:0]          subpanel;
    logic                 done;
    logic                 frame_ok;
    logic                 sync_err;
    logic [4:0]           bpp;
    logic                 color16;
    logic [9:0]           pix_offset;
    logic [DIM_W+1:0]     line_step;
    logic [9:0]           first_line;
    logic [DIM_W-1:0]     line_count;

    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk;

    fhdr_decoder #(.DIM_W(DIM_W), .BUF_W(BUF_W)) uut (
        .clk          (clk),
        .rst_n        (rst_n),
        .start        (start),
        .ctrl_enable  (ctrl_enable),
        .load_mode    (load_mode),
        .active_panel (active_panel),
        .hdr_word     (hdr_word),
        .width        (width),
        .height       (height),
        .buf_size     (buf_size),
        .subpanel     (subpanel),
        .done         (done),
        .frame_ok     (frame_ok),
        .sync_err     (sync_err),
        .bpp          (bpp),
        .color16      (color16),
        .pix_offset   (pix_offset),
        .line_step    (line_step),
        .first_line   (first_line),
        .line_count   (line_count)
    );

    task automatic check(input string what, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", what, act, exp);
        end
    endtask

    task automatic apply(input vec_t v, input logic en, input logic go);
        @(negedge clk);
        hdr_word     = v.hdr;
        active_panel = v.act;
        load_mode    = v.mode;
        width        = v.w;
        height       = v.h;
        buf_size     = v.bsz;
        subpanel     = v.sub;
        ctrl_enable  = en;
        start        = go;
        @(negedge clk);
        start        = 1'b0;
    endtask

    task automatic check_vec(input int i, input vec_t v);
        string t;
        t = $sformatf("vec%0d", i);
        check({t, " R2 done"},           32'(done),       32'd1);
        check({t, " R3 bpp"},            32'(bpp),        32'(v.e_bpp));
        check({t, " R6 offset"},         32'(pix_offset), 32'(v.e_off));
        check({t, " R5 color16"},        32'(color16),    32'(v.e_c16));
        check({t, " R8 line_step"},      32'(line_step),  32'(v.e_step));
        check({t, " R9 R10 first_line"}, 32'(first_line), 32'(v.e_first));
        check({t, " R9 R11 line_count"}, 32'(line_count), 32'(v.e_cnt));
        check({t, " R7 frame_ok"},       32'(frame_ok),   32'(v.e_ok));
        check({t, " R7 sync_err"},       32'(sync_err),   32'(v.e_err));
    endtask

    // Watchdog: a hung run counts as a failure
    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=expired expected=finished");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        rst_n = 1'b0; start = 1'b0; ctrl_enable = 1'b0; load_mode = 2'd0;
        active_panel = 1'b0; hdr_word = '0; width = '0; height = '0;
        buf_size = '0; subpanel = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        check("R1 done",       32'(done),       32'd0);
        check("R1 frame_ok",   32'(frame_ok),   32'd0);
        check("R1 sync_err",   32'(sync_err),   32'd0);
        check("R1 bpp",        32'(bpp),        32'd0);
        check("R1 line_step",  32'(line_step),  32'd0);
        check("R1 line_count", 32'(line_count), 32'd0);

        for (int i = 0; i < NVEC; i++) begin
            apply(VECS[i], 1'b1, 1'b1);
            check_vec(i, VECS[i]);
        end

        // R2: done and R7 sync_err are single-cycle pulses
        apply(VECS[4], 1'b1, 1'b1);
        check("R7 sync_err first cycle", 32'(sync_err), 32'd1);
        @(negedge clk);
        check("R2 done one cycle", 32'(done), 32'd0);
        check("R7 sync_err one cycle", 32'(sync_err), 32'd0);

        // R4: unsupported code with tiny buffer raises no sync error
        apply(VECS[7], 1'b1, 1'b1);
        check("R4 done", 32'(done), 32'd1);
        check("R4 sync_err", 32'(sync_err), 32'd0);
        check("R4 bpp", 32'(bpp), 32'd0);

        // R2: start ignored while disabled, results held
        apply(VECS[0], 1'b1, 1'b1);
        apply(VECS[2], 1'b0, 1'b1);
        check("R2 disabled done", 32'(done), 32'd0);
        check("R2 disabled bpp held", 32'(bpp), 32'd2);
        check("R2 disabled step held", 32'(line_step), 32'd80);

        // R2: start ignored in load mode 1
        begin
            vec_t v;
            v = VECS[2];
            v.mode = 2'd1;
            apply(v, 1'b1, 1'b1);
            check("R2 mode1 done", 32'(done), 32'd0);
            check("R2 mode1 bpp held", 32'(bpp), 32'd2);
            check("R2 mode1 offset held", 32'(pix_offset), 32'd32);
        end

        // R1: reset mid-run clears results
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        check("R1 reset bpp", 32'(bpp), 32'd0);
        check("R1 reset offset", 32'(pix_offset), 32'd0);
        rst_n = 1'b1;
        @(negedge clk);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule